// File: doc/BRIEF.md
# Aliased Control Register Window Decoder

This block sits between a core's data bus and a bank of on-chip control registers. The bank can be reached through two 16 MB address windows. In the direct window the top address byte is 0xFF. In the translated window the top address byte is 0x1F. Both windows map onto the same physical registers, so each register has exactly one address in each window. The translated window is there because physical page numbers only span a 29-bit space. Page-table entries can point at the translated window, while the direct window is used only by privileged code.

Each request is a single cycle. It carries an address, a write flag, write data, the current privilege level and a flag that says whether address translation is active. In that same cycle the block reports whether a register was decoded, which register it was, and whether the access breaks a window rule. A read always returns a response one cycle later. When the read was refused, that response carries zero data. The response logic is a small state machine with three states:

- `ST_IDLE`: no response is pending.
- `ST_RD_GRANT`: the last cycle held a permitted read, and its captured data is returned.
- `ST_RD_BLOCK`: the last cycle held a refused read, and zero is returned.

Transitions are taken on every clock from any state:

- *take_grant*: a permitted read was decoded, so the next state is `ST_RD_GRANT`.
- *take_block*: a refused read was decoded, so the next state is `ST_RD_BLOCK`.
- *go_idle*: anything else happened, so the next state is `ST_IDLE`.

Top module: `ctrlwin_decoder`

## Requirements
- R1: The direct window is any address whose bits [31:24] equal 0xFF. Within it, bits [23:6] must be zero and bits [5:2] give the register index (16 registers of 32 bits). Bits [1:0] are ignored. For a valid request, `hit` rises in the same cycle and `reg_sel` shows the index.
- R2: The translated window is any address whose bits [31:24] equal 0x1F. It uses the same offset rules as R1 and reaches the same physical registers. A value written through one window reads back through the other.
- R3: A direct-window access with `priv_mode`=0 (user) raises `addr_err` in the same cycle. A write is discarded. A read responds with data zero.
- R4: A translated-window access with `xlat_on`=0 raises `undef_acc` in the same cycle. A write is discarded. A read responds with data zero.
- R5: A translated-window access with `xlat_on`=1 is permitted in both user and privileged mode.
- R6: An address outside both windows, or with nonzero offset bits [23:6], deasserts `hit`, raises no flag, gives no response and changes no register.
- R7: A read that hits produces `rsp_valid` exactly one cycle later, with the register value as it stood at the read's clock edge. A permitted write updates the register on the clock edge of its request. Back-to-back reads each get their own response.
- R8: After reset every register holds 0 and `rsp_valid` is low.
- R9: `hit`, `addr_err` and `undef_acc` are low whenever `req_valid` is low. A privileged direct-window access is permitted whatever the value of `xlat_on`.
- R10: A write never produces `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Bus address |
| req_wdata | input | 32 | Write data |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| xlat_on | input | 1 | 1 = address translation active |
| hit | output | 1 | Address decoded to a register (same cycle) |
| reg_sel | output | 4 | Decoded register index (same cycle) |
| addr_err | output | 1 | User access to the direct window (same cycle) |
| undef_acc | output | 1 | Translated-window access without translation (same cycle) |
| rsp_valid | output | 1 | Read response valid (one cycle after the read) |
| rsp_rdata | output | 32 | Read response data, zero for refused reads |

## Verification
Some results are combinational and belong to the request cycle itself: `hit`, `reg_sel`, `addr_err` and `undef_acc`. The driver compares them shortly after it applies each request, before the next clock edge.

Read responses are due exactly one edge after the request. The driver tags each expected response with that due cycle and pushes it into a queue. A monitor samples on the falling edge. It flags a missing response, an early response, an unexpected response and a wrong value.

The effect of a write is observed through a later read. This covers a suppressed write as well as an aliased one.

// File: rtl/ctrlwin_pkg.sv
package ctrlwin_pkg;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_DIRECT,
        WIN_XLAT
    } win_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_GRANT,
        ST_RD_BLOCK
    } rsp_state_e;

endpackage

// File: rtl/ctrlwin_match.sv
module ctrlwin_match
    import ctrlwin_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int TAG_W    = 8,
    parameter logic [TAG_W-1:0] HI_TAG = 8'hFF,
    parameter logic [TAG_W-1:0] LO_TAG = 8'h1F,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4,
    parameter int LSB_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic              in_range,
    output logic [IDX_W-1:0]  idx
);
    localparam int OFS_W = ADDR_W - TAG_W;
    localparam int PAD_W = OFS_W - IDX_W - LSB_W;

    logic [TAG_W-1:0] tag;
    logic             pad_zero;

    assign tag = addr[ADDR_W-1 -: TAG_W];
    assign idx = addr[IDX_W+LSB_W-1:LSB_W];

    always_comb begin
        if (tag == HI_TAG) begin
            win = WIN_DIRECT;
        end else if (tag == LO_TAG) begin
            win = WIN_XLAT;
        end else begin
            win = WIN_NONE;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign pad_zero = (addr[OFS_W-1:IDX_W+LSB_W] == '0);
        end else begin : g_nopad
            assign pad_zero = 1'b1;
        end
    endgenerate

    assign in_range = pad_zero && (int'(idx) < NUM_REGS);

endmodule

// File: rtl/ctrlwin_guard.sv
module ctrlwin_guard
    import ctrlwin_pkg::*;
(
    input  logic req_valid,
    input  logic req_write,
    input  win_e win,
    input  logic in_range,
    input  logic priv_mode,
    input  logic xlat_on,
    output logic hit,
    output logic addr_err,
    output logic undef_acc,
    output logic wr_grant,
    output logic rd_grant,
    output logic rd_block
);
    logic allow;

    always_comb begin
        hit       = req_valid && (win != WIN_NONE) && in_range;
        addr_err  = hit && (win == WIN_DIRECT) && !priv_mode;
        undef_acc = hit && (win == WIN_XLAT) && !xlat_on;
        allow     = hit && !addr_err && !undef_acc;
        wr_grant  = allow && req_write;
        rd_grant  = allow && !req_write;
        rd_block  = hit && !req_write && !allow;
    end

endmodule

// File: rtl/ctrlwin_regfile.sv
module ctrlwin_regfile #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = 4,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cell_q [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= RST_VAL;
                end else if (wr_en && (int'(idx) == g)) begin
                    q <= wdata;
                end
            end
            assign cell_q[g] = q;
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(idx) == i) begin
                rdata = cell_q[i];
            end
        end
    end

endmodule

// File: rtl/ctrlwin_decoder.sv
module ctrlwin_decoder
    import ctrlwin_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int TAG_W    = 8,
    parameter logic [TAG_W-1:0] HI_TAG = 8'hFF,
    parameter logic [TAG_W-1:0] LO_TAG = 8'h1F,
    parameter int IDX_W    = $clog2(NUM_REGS),
    parameter int LSB_W    = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              priv_mode,
    input  logic              xlat_on,
    output logic              hit,
    output logic [IDX_W-1:0]  reg_sel,
    output logic              addr_err,
    output logic              undef_acc,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    win_e              win;
    logic              in_range;
    logic              wr_grant;
    logic              rd_grant;
    logic              rd_block;
    logic [DATA_W-1:0] bank_rdata;
    logic [DATA_W-1:0] rd_q;
    rsp_state_e        state_q;
    rsp_state_e        state_d;

    ctrlwin_match #(
        .ADDR_W  (ADDR_W),
        .TAG_W   (TAG_W),
        .HI_TAG  (HI_TAG),
        .LO_TAG  (LO_TAG),
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W),
        .LSB_W   (LSB_W)
    ) match_i (
        .addr    (req_addr),
        .win     (win),
        .in_range(in_range),
        .idx     (reg_sel)
    );

    ctrlwin_guard guard_i (
        .req_valid(req_valid),
        .req_write(req_write),
        .win      (win),
        .in_range (in_range),
        .priv_mode(priv_mode),
        .xlat_on  (xlat_on),
        .hit      (hit),
        .addr_err (addr_err),
        .undef_acc(undef_acc),
        .wr_grant (wr_grant),
        .rd_grant (rd_grant),
        .rd_block (rd_block)
    );

    ctrlwin_regfile #(
        .DATA_W  (DATA_W),
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W)
    ) bank_i (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_grant),
        .idx  (reg_sel),
        .wdata(req_wdata),
        .rdata(bank_rdata)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read data capture at the strobe edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_grant) begin
            rd_q <= bank_rdata;
        end else begin
            rd_q <= '0;
        end
    end

    // Next-state logic: take_grant / take_block / go_idle
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RD_GRANT, ST_RD_BLOCK: begin
                if (rd_grant) begin
                    state_d = ST_RD_GRANT;
                end else if (rd_block) begin
                    state_d = ST_RD_BLOCK;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
                rsp_rdata = '0;
            end
            ST_RD_GRANT: begin
                rsp_valid = 1'b1;
                rsp_rdata = rd_q;
            end
            ST_RD_BLOCK: begin
                rsp_valid = 1'b1;
                rsp_rdata = '0;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/ctrlwin_decoder_chk.sv
module ctrlwin_decoder_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              priv_mode,
    input logic              xlat_on,
    input logic              hit,
    input logic              addr_err,
    input logic              undef_acc,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata
);
    // R3
    user_direct_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (req_addr[ADDR_W-1 -: 8] == 8'hFF) && !priv_mode && hit);

    // R4
    undef_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_acc |-> (req_addr[ADDR_W-1 -: 8] == 8'h1F) && !xlat_on && hit);

    // R3
    blocked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (addr_err || undef_acc)) |=> (rsp_valid && rsp_rdata == '0));

    // R7
    read_rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && hit) |=> rsp_valid);

    // R10
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write && hit) |=> !rsp_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !hit && !addr_err && !undef_acc);

    // R6
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> !addr_err && !undef_acc);

endmodule

bind ctrlwin_decoder ctrlwin_decoder_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .priv_mode(priv_mode),
    .xlat_on  (xlat_on),
    .hit      (hit),
    .addr_err (addr_err),
    .undef_acc(undef_acc),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
);

// File: tb/ctrlwin_decoder_tb.sv
module ctrlwin_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        priv_mode = 1'b0;
    logic        xlat_on = 1'b0;
    logic        hit;
    logic [3:0]  reg_sel;
    logic        addr_err;
    logic        undef_acc;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] data;
        int          due;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    ctrlwin_decoder dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .priv_mode(priv_mode),
        .xlat_on  (xlat_on),
        .hit      (hit),
        .reg_sel  (reg_sel),
        .addr_err (addr_err),
        .undef_acc(undef_acc),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Driver: applies one request, checks same-cycle results, queues a response
    task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                          input logic priv, input logic xl,
                          input logic e_hit, input logic e_aerr, input logic e_undef,
                          input logic [31:0] e_data, input string tag);
        exp_t item;
        @(posedge clk);
        #1;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        priv_mode = priv;
        xlat_on   = xl;
        #1;
        check_eq({tag, " hit"}, {31'd0, hit}, {31'd0, e_hit});
        check_eq({tag, " addr_err"}, {31'd0, addr_err}, {31'd0, e_aerr});
        check_eq({tag, " undef_acc"}, {31'd0, undef_acc}, {31'd0, e_undef});
        if (e_hit) begin
            check_eq({tag, " reg_sel"}, {28'd0, reg_sel}, {28'd0, addr[5:2]});
        end
        if (!wr && e_hit) begin
            item.data = e_data;
            item.due  = cyc + 1;
            item.tag  = tag;
            exp_q.push_back(item);
        end
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // Monitor: compares responses against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                check_eq({exp_q[0].tag, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
                check_eq({exp_q[0].tag, " rsp_rdata"}, rsp_rdata, exp_q[0].data);
                void'(exp_q.pop_front());
            end else if (rsp_valid) begin
                check_eq("R10/R6 unexpected rsp_valid", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_eq("R8 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;

        // R8: reset value of register 2
        access(1'b0, 32'hFF00_0008, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, "R8 reset value");
        // R1 / R9: privileged direct write, translation off
        access(1'b1, 32'hFF00_0004, 32'hA5A5_0001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R1 direct write");
        // R7: read-back one cycle later
        access(1'b0, 32'hFF00_0004, '0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'hA5A5_0001, "R7 direct read");
        // R2 / R5: user read through translated alias
        access(1'b0, 32'h1F00_0004, '0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'hA5A5_0001, "R2 alias read");
        // R5: user write via translated window, read via direct
        access(1'b1, 32'h1F00_003C, 32'h0000_1234, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R5 xlat user write");
        access(1'b0, 32'hFF00_003C, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_1234, "R2 alias readback");
        // R3: user write to direct window suppressed, read returns zero
        access(1'b1, 32'hFF00_0004, 32'hDEAD_DEAD, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, "R3 user direct write");
        access(1'b0, 32'hFF00_0004, '0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, "R3 user direct read");
        access(1'b0, 32'hFF00_0004, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'hA5A5_0001, "R3 write suppressed");
        // R4: translated window without translation
        access(1'b1, 32'h1F00_0004, 32'hBEEF_BEEF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '0, "R4 untranslated write");
        access(1'b0, 32'h1F00_0004, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0, "R4 untranslated read");
        access(1'b0, 32'hFF00_0004, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'hA5A5_0001, "R4 write suppressed");
        // R6: misses
        access(1'b1, 32'h2000_0004, 32'h5555_5555, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R6 outside windows");
        access(1'b1, 32'hFF00_0044, 32'h6666_6666, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R6 offset out of range");
        access(1'b0, 32'h1E00_0004, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R6 miss read");
        access(1'b0, 32'hFF00_0004, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'hA5A5_0001, "R6 no side effect");
        // R1: byte-lane bits ignored
        access(1'b0, 32'hFF00_0007, '0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'hA5A5_0001, "R1 low bits ignored");
        // R7: write then back-to-back reads of different registers
        access(1'b1, 32'hFF00_0020, 32'h0BAD_F00D, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0, "R7 write reg8");
        access(1'b0, 32'hFF00_0020, '0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0BAD_F00D, "R7 b2b read reg8");
        access(1'b0, 32'h1F00_003C, '0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_1234, "R7 b2b read reg15");
        // R9: no request, flags quiet
        idle_cycle();
        req_addr  = 32'hFF00_0004;
        priv_mode = 1'b0;
        xlat_on   = 1'b0;
        #1;
        check_eq("R9 idle hit", {31'd0, hit}, 32'd0);
        check_eq("R9 idle addr_err", {31'd0, addr_err}, 32'd0);
        req_addr = 32'h1F00_0004;
        #1;
        check_eq("R9 idle undef_acc", {31'd0, undef_acc}, 32'd0);

        repeat (3) idle_cycle();
        @(negedge clk);
        check_eq("R7 all responses seen", exp_q.size(), 32'd0);
        done = 1'b1;
        finish_run();
    end

endmodule